// File: doc/BRIEF.md
# SPI Slave Hold Controller

This block is the pause front end of a serial-memory slave on an SPI bus. It watches chip select, serial clock, serial data in and an active-low hold request. While the slave is selected, the host may freeze a transfer in flight without dropping chip select. The block then stops qualifying clock edges for the shift logic and releases the serial data output. Once the hold request is withdrawn, the transfer carries on from the exact bit where it stopped.

All four bus inputs are oversampled by the core clock through a configurable synchronizer. Hold entry and hold exit only take effect in a sample where the serial clock is low. A hold edge that arrives while the clock is high is therefore deferred to the next low phase. Deselecting the slave ends any hold, drops the partially received word, and sends a one-cycle reset pulse to the command decoder. A small receive shifter is included so that the qualified edges can be observed at the ports.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, and whenever chip select is high, `hold_o`, `sdo_oe_o`, `shift_en_o` and `rx_vld_o` are 0.
- R2: A low hold request while chip select is high has no effect: `hold_o` stays 0.
- R3: While selected, hold is entered (`hold_o`=1) once hold request and serial clock are both sampled low. If the request falls while the clock is high, entry waits for the next clock-low sample.
- R4: Hold is left (`hold_o`=0, `sdo_oe_o`=1) once the hold request is sampled high together with a low serial clock. A release made while the clock is high waits for the next clock-low sample.
- R5: During hold, `sdo_oe_o` is 0 and `shift_en_o` stays 0. Serial clock toggles and data-in levels during hold alter no state.
- R6: `shift_en_o` pulses for one cycle on each sampled rising serial clock edge while selected and not held. Each such pulse shifts one data-in bit, MSB first. On the WORD_W-th bit, `rx_byte_o` is loaded and `rx_vld_o` pulses for one cycle. Bit count and partial word are kept across a hold.
- R7: A rising chip select produces exactly one one-cycle `dec_rst_o` pulse. It clears hold and discards the partial word, so the next selection starts at bit 0.
- R8: A selection that starts with the hold request low begins in hold. It resumes only under the exit rule of R4.
- R9: Both idle clock levels work. With the clock idle high at selection (mode 3), no edge is counted until the first real rising edge. With the clock idle low (mode 0), the first rising edge is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold request, active low |
| hold_o | output | 1 | Internal hold flag |
| shift_en_o | output | 1 | Qualified clock-edge strobe for shift logic |
| sdo_oe_o | output | 1 | Output enable for serial data out |
| dec_rst_o | output | 1 | One-cycle reset pulse to command decoder |
| rx_byte_o | output | WORD_W | Last fully received word |
| rx_vld_o | output | 1 | One-cycle strobe when rx_byte_o is loaded |

## Verification
A table of level combinations walks the hold state through aligned entry and exit, deferred entry and exit with the clock high, and a hold request asserted while deselected. It also covers a selection that starts held. This separates a level-and-phase rule from a pure edge rule or from an unqualified hold. Directed transfers then insert a hold in the middle of a word and toggle clock and data during it. If the resumed word comes out intact, the bit count was preserved and the held edges were masked. Deselect during hold, followed by a fresh word, shows the partial word is dropped. A mode-3 selection with the clock idle high checks that no spurious first edge is counted.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_ACTIVE = 2'd1,
    HS_HOLD   = 2'd2
  } hs_state_e;

  localparam int unsigned BUS_W = 4;
  // synchronizer bus layout
  localparam int unsigned IDX_SDI  = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_HOLD = 2;
  localparam int unsigned IDX_CS   = 3;
endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= RST_VAL;
          else if (s == 0) stg_q[s] <= d_i;
          else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/shc_hold_fsm.sv
module shc_hold_fsm
  import shc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cs_ni,
  input  logic      sclk_i,
  input  logic      hold_ni,
  output hs_state_e state_o,
  output logic      dec_rst_o
);
  hs_state_e state_q, state_d;
  logic      cs_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: begin
        if (!cs_ni) state_d = hold_ni ? HS_ACTIVE : HS_HOLD;
      end
      HS_ACTIVE: begin
        if (cs_ni) state_d = HS_IDLE;
        else if (!hold_ni && !sclk_i) state_d = HS_HOLD;
      end
      HS_HOLD: begin
        if (cs_ni) state_d = HS_IDLE;
        else if (hold_ni && !sclk_i) state_d = HS_ACTIVE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cs_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_ni;
    end
  end

  assign state_o   = state_q;
  assign dec_rst_o = cs_ni && !cs_q;

  // R3: entry only from a clock-low, hold-low sample
  assert_enter_clk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_HOLD && $past(state_q) == HS_ACTIVE) |-> (!$past(sclk_i) && !$past(hold_ni)));

  // R4: exit only from a clock-low, hold-high sample
  assert_exit_clk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_ACTIVE && $past(state_q) == HS_HOLD) |-> (!$past(sclk_i) && $past(hold_ni)));

  // R2: any non-idle state requires a selected bus one sample earlier
  assert_sel_needed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != HS_IDLE) |-> !$past(cs_ni));

  // R7: decoder reset is a single-cycle pulse
  assert_dec_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_rst_o |=> !dec_rst_o);
endmodule

// File: rtl/shc_clk_qual.sv
module shc_clk_qual
  import shc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  hs_state_e state_i,
  output logic      shift_en_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign shift_en_o = sclk_i && !sclk_q && (state_i == HS_ACTIVE);

  // R5: no qualified edge while paused
  assert_no_edge_in_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == HS_HOLD) |-> !shift_en_o);

  // R6: a qualified edge needs a low clock sample just before
  assert_edge_after_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> !$past(sclk_i));
endmodule

// File: rtl/shc_shifter.sv
module shc_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] rx_byte_o,
  output logic              rx_vld_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_bit;
  logic [WORD_W-1:0] sh_next;

  assign last_bit = (cnt_q == LAST);
  generate
    if (WORD_W > 1) begin : g_wide
      assign sh_next = {sh_q[WORD_W-2:0], sdi_i};
    end else begin : g_narrow
      assign sh_next = sdi_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      rx_byte_o <= '0;
      rx_vld_o  <= 1'b0;
    end else begin
      rx_vld_o <= 1'b0;
      if (clr_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (shift_en_i) begin
        sh_q <= sh_next;
        if (last_bit) begin
          cnt_q     <= '0;
          rx_byte_o <= sh_next;
          rx_vld_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R6: position is kept while no edge is qualified
  assert_cnt_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !clr_i) |=> ($stable(cnt_q) && $stable(sh_q)));

  // R6: a word strobe always follows a qualified edge
  assert_vld_from_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> $past(shift_en_i));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import shc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WORD_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              hold_ni,
  output logic              hold_o,
  output logic              shift_en_o,
  output logic              sdo_oe_o,
  output logic              dec_rst_o,
  output logic [WORD_W-1:0] rx_byte_o,
  output logic              rx_vld_o
);
  localparam logic [BUS_W-1:0] BUS_RST = 4'b1100;

  logic [BUS_W-1:0] bus_raw, bus_s;
  hs_state_e        state;
  logic             cs_s;

  assign bus_raw[IDX_SDI]  = sdi_i;
  assign bus_raw[IDX_SCLK] = sclk_i;
  assign bus_raw[IDX_HOLD] = hold_ni;
  assign bus_raw[IDX_CS]   = cs_ni;
  assign cs_s              = bus_s[IDX_CS];

  shc_sync #(
    .W      (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  shc_hold_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_s),
    .sclk_i   (bus_s[IDX_SCLK]),
    .hold_ni  (bus_s[IDX_HOLD]),
    .state_o  (state),
    .dec_rst_o(dec_rst_o)
  );

  shc_clk_qual i_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (bus_s[IDX_SCLK]),
    .state_i   (state),
    .shift_en_o(shift_en_o)
  );

  shc_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cs_s),
    .shift_en_i(shift_en_o),
    .sdi_i     (bus_s[IDX_SDI]),
    .rx_byte_o (rx_byte_o),
    .rx_vld_o  (rx_vld_o)
  );

  assign hold_o   = (state == HS_HOLD);
  assign sdo_oe_o = (state == HS_ACTIVE);

  // R5: output driver never enabled in hold, never both asserted with a strobe
  assert_oe_hold_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hold_o, sdo_oe_o}) && !(hold_o && shift_en_o));

  // R1: deselected bus keeps outputs quiet
  assert_quiet_desel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_s) && cs_s) |-> (!hold_o && !sdo_oe_o && !shift_en_o));
endmodule

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
  localparam int WORD_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic hold, shift_en, sdo_oe, dec_rst, rx_vld;
  logic [WORD_W-1:0] rx_byte;

  int errors = 0, checks = 0, cyc = 0;
  int n_shift = 0, n_vld = 0, n_drst = 0, n_hold = 0;
  logic [WORD_W-1:0] last_byte = '0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(2), .WORD_W(WORD_W)) i_spi_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .hold_ni(hold_n), .hold_o(hold), .shift_en_o(shift_en), .sdo_oe_o(sdo_oe),
    .dec_rst_o(dec_rst), .rx_byte_o(rx_byte), .rx_vld_o(rx_vld)
  );

  always @(negedge clk) begin
    cyc++;
    if (shift_en) n_shift++;
    if (rx_vld) begin n_vld++; last_byte = rx_byte; end
    if (dec_rst) n_drst++;
    if (hold) n_hold++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    wait_cyc(5);
    @(negedge clk);
    #0;
  endtask

  task automatic clr_mon();
    @(posedge clk); #1;
    n_shift = 0; n_vld = 0; n_drst = 0; n_hold = 0;
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; sdi = b; wait_cyc(4);
    sclk = 1'b1; wait_cyc(4);
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w, input int from, input int to);
    for (int i = from; i <= to; i++) send_bit(w[WORD_W-1-i]);
  endtask

  // {cs_n, sclk, hold_n, exp_hold, exp_oe, req}
  typedef struct packed {
    logic cs_n; logic sclk; logic hold_n; logic e_hold; logic e_oe; logic [3:0] req;
  } vec_t;
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd1},  // R1 idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd2},  // R2 hold while deselected
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd9},  // R9 mode 0 select
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'd9},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,4'd3},  // R3 deferred entry
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3},  // R3 entry at low
    '{1'b0,1'b1,1'b0,1'b1,1'b0,4'd5},  // R5 clock ignored
    '{1'b0,1'b1,1'b1,1'b1,1'b0,4'd4},  // R4 deferred exit
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd4},  // R4 exit at low
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3},  // R3 aligned entry
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd4},  // R4 aligned exit
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd3},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7 deselect clears hold
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd8},  // R8 select while held
    '{1'b0,1'b1,1'b1,1'b1,1'b0,4'd8},  // R8 release with clock high waits
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd8},  // R8 resume
    '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd1}
  };

  initial begin
    wait_cyc(3);
    @(negedge clk);
    chk("R1 reset hold", int'(hold), 0);
    chk("R1 reset oe", int'(sdo_oe), 0);
    rst_n = 1'b1;
    settle();
    chk("R1 idle strobe", int'(shift_en), 0);
    chk("R1 idle vld", int'(rx_vld), 0);

    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      cs_n = VEC[v].cs_n; sclk = VEC[v].sclk; hold_n = VEC[v].hold_n;
      settle();
      checks++;
      if (hold !== VEC[v].e_hold || sdo_oe !== VEC[v].e_oe) begin
        errors++;
        $display("FAIL R%0d vec %0d: actual hold=%0b oe=%0b expected hold=%0b oe=%0b",
                 VEC[v].req, v, hold, sdo_oe, VEC[v].e_hold, VEC[v].e_oe);
      end
    end

    // R6 / R5: hold in the middle of a word, clock and data toggled while held
    clr_mon();
    cs_n = 1'b0; sclk = 1'b0; hold_n = 1'b1; settle();
    send_word(8'hA5, 0, 3);
    sclk = 1'b0; wait_cyc(4);
    hold_n = 1'b0; settle();
    chk("R3 hold mid-word", int'(hold), 1);
    for (int k = 0; k < 3; k++) begin
      sdi = k[0]; sclk = 1'b1; wait_cyc(4); sclk = 1'b0; wait_cyc(4);
    end
    settle();
    chk("R5 edges masked in hold", n_shift, 4);
    chk("R5 oe off in hold", int'(sdo_oe), 0);
    hold_n = 1'b1; settle();
    chk("R4 resumed", int'(sdo_oe), 1);
    send_word(8'hA5, 4, 7);
    settle();
    chk("R6 word across hold", int'(last_byte), 8'hA5);
    chk("R6 one word strobe", n_vld, 1);
    chk("R6 edge count", n_shift, 8);
    sclk = 1'b0; wait_cyc(2);
    cs_n = 1'b1; settle();
    chk("R7 decoder reset pulses", n_drst, 1);
    chk("R1 deselected oe", int'(sdo_oe), 0);

    // R7: deselect during hold drops partial word
    clr_mon();
    cs_n = 1'b0; settle();
    send_word(8'hFF, 0, 2);
    sclk = 1'b0; hold_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk("R7 hold cleared", int'(hold), 0);
    hold_n = 1'b1; cs_n = 1'b0; settle();
    send_word(8'h3C, 0, 7);
    settle();
    chk("R7 fresh word", int'(last_byte), 8'h3C);
    chk("R7 strobes", n_vld, 1);
    sclk = 1'b0; wait_cyc(2); cs_n = 1'b1; settle();

    // R9: mode 3, clock idle high at selection
    clr_mon();
    sclk = 1'b1; settle();
    cs_n = 1'b0; settle();
    chk("R9 no spurious edge", n_shift, 0);
    chk("R9 active", int'(sdo_oe), 1);
    send_word(8'h96, 0, 7);
    settle();
    chk("R9 mode 3 word", int'(last_byte), 8'h96);
    chk("R9 edge count", n_shift, 8);

    // R3: hold pulse fully inside a clock-high phase never takes effect
    clr_mon();
    hold_n = 1'b0; wait_cyc(3); hold_n = 1'b1; wait_cyc(3);
    sclk = 1'b0; settle();
    chk("R3 pulse in high phase ignored", n_hold, 0);
    cs_n = 1'b1; settle();

    // R2: hold request while deselected, then normal selection
    clr_mon();
    hold_n = 1'b0; settle();
    chk("R2 no hold deselected", n_hold, 0);
    hold_n = 1'b1; settle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule